// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache with Uncached Alias Window

This block puts a small direct-mapped write-back data cache between a word-wide requester and a built-in physical memory model. The upper three bits of each request address select a window. Two windows alias the same physical space, because clearing those three bits gives the physical address. Requests in the cached window are looked up in the cache. On a miss the block allocates the line: it writes back a dirty victim, then fills the new line, and both transfers are whole-line bursts on the memory side. Requests in the uncached window go straight to memory. They never look up, fill, clean or invalidate a line.

The block models the coherency hazard between these two paths on purpose. Memory written through the uncached window stays hidden behind a valid cached line. A dirty line evicted later overwrites the newer memory contents. Software removes all dirty data by reading a cache-sized span of cached addresses, which walks every index. Addresses outside both windows are still served to memory without caching, and they are reported with an error flag.

The requester presents a request and holds it until `cpu_ready` is high for one cycle. Hits and uncached accesses complete in the cycle they are presented. A miss stalls the requester for the burst cycles.

Top module: `alias_wb_cache`

## Requirements
- R1: A request (`cpu_valid`, `cpu_we`, `cpu_addr`, `cpu_wdata`) is held stable until `cpu_ready` is high for exactly one cycle. `cpu_ready` is never high without `cpu_valid`, and for reads `cpu_rdata` is valid in the `cpu_ready` cycle.
- R2: Address bits [31:29] = 3'b100 select the cached window and 3'b101 select the uncached window. The physical address is the request address with bits [31:29] cleared, so 0x8000_0100 and 0xA000_0100 reach the same physical word.
- R3: A cached access that hits a valid line with a matching tag completes in the cycle it is presented, with zero wait cycles.
- R4: A cached write marks its line dirty and does not update memory. An uncached read of the same address afterwards still returns the older memory value.
- R5: Uncached reads and writes access memory directly and leave every valid bit, dirty bit and tag unchanged. A later cached hit on that address returns the cached value, not the newer memory value.
- R6: A cached miss on an invalid or clean line fills the line in an 8-beat burst and completes 9 cycles after it is presented. A miss on a dirty line first writes back in an 8-beat burst and completes after 17 cycles. `cpu_ready` stays low throughout.
- R7: Evicting a dirty line writes back all eight words of the line. This overwrites any memory words that were changed through the uncached window in the meantime.
- R8: Cached reads across 64 consecutive 32-byte lines, with a tag that differs from the resident lines, evict every line and leave all previously dirty data in memory.
- R9: A request with bits [31:29] outside 3'b100 and 3'b101 is served as an uncached access at the address with bits [31:29] cleared. It completes with `cpu_err` high. `cpu_err` is low for requests in either window.
- R10: After reset, every line is invalid and `cpu_ready` and `cpu_err` are low while no request is presented. The first cached access misses.
- R11: A cached write miss allocates the line. The written word takes the new value and the other seven words come from memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_valid | input | 1 | Request present |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address of the word, word aligned |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ready` |
| cpu_err | output | 1 | Completed request was outside both windows |

## Verification
The checker assumes that the requester keeps address, direction and write data unchanged from the first cycle of a request until its `cpu_ready` cycle, and that addresses are word aligned. The bench drives each request from a task at the falling edge. It holds the request until the ready cycle and drops `cpu_valid` just after the completing rising edge, so no request is ever modified or retired early. The bench uses only physical addresses below 4 KB. The memory model folds higher addresses onto the same words, so the expected values stay unambiguous.

// File: rtl/awc_pkg.sv
package awc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WBACK = 2'd1,
    ST_FILL  = 2'd2
  } ctl_state_t;

  typedef enum logic [1:0] {
    WIN_CACHED   = 2'd0,
    WIN_UNCACHED = 2'd1,
    WIN_OTHER    = 2'd2
  } win_t;
endpackage

// File: rtl/awc_rst_sync.sv
module awc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/awc_decode.sv
module awc_decode
  import awc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  output win_t              win,
  output logic [ADDR_W-4:0] phys
);
  always_comb begin
    phys = addr[ADDR_W-4:0];
    case (addr[ADDR_W-1 -: 3])
      3'b100:  win = WIN_CACHED;
      3'b101:  win = WIN_UNCACHED;
      default: win = WIN_OTHER;
    endcase
  end
endmodule

// File: rtl/awc_line_store.sv
module awc_line_store #(
  parameter int NUM_LINES  = 64,
  parameter int LINE_WORDS = 8,
  parameter int TAG_W      = 18,
  parameter int DATA_W     = 32,
  localparam int IDX_W     = $clog2(NUM_LINES),
  localparam int WORD_W    = $clog2(LINE_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] word,
  output logic [DATA_W-1:0] rd_data,
  output logic [TAG_W-1:0]  rd_tag,
  output logic              rd_valid,
  output logic              rd_dirty,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              set_dirty,
  input  logic              fill_done,
  input  logic [TAG_W-1:0]  fill_tag,
  output logic [NUM_LINES-1:0] valid_vec,
  output logic [NUM_LINES-1:0] dirty_vec
);
  logic [DATA_W-1:0] data_q [NUM_LINES*LINE_WORDS];
  logic [TAG_W-1:0]  tag_q  [NUM_LINES];
  logic [NUM_LINES-1:0] valid_q, valid_d, dirty_q, dirty_d;

  assign rd_data  = data_q[{idx, word}];
  assign rd_tag   = tag_q[idx];
  assign rd_valid = valid_q[idx];
  assign rd_dirty = dirty_q[idx];
  assign valid_vec = valid_q;
  assign dirty_vec = dirty_q;

  always_ff @(posedge clk) begin
    if (wr_en) data_q[{idx, word}] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (fill_done) tag_q[idx] <= fill_tag;
  end

  always_comb begin
    valid_d = valid_q;
    dirty_d = dirty_q;
    if (fill_done) begin
      valid_d[idx] = 1'b1;
      dirty_d[idx] = 1'b0;
    end
    if (set_dirty) dirty_d[idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      valid_q <= valid_d;
      dirty_q <= dirty_d;
    end
  end
endmodule

// File: rtl/awc_phys_mem.sv
module awc_phys_mem #(
  parameter int AW     = 27,
  parameter int DEPTH  = 1024,
  parameter int DATA_W = 32,
  localparam int MEM_AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic unused_hi;

  assign unused_hi = ^addr[AW-1:MEM_AW];
  assign rdata = mem_q[addr[MEM_AW-1:0]];

  always_ff @(posedge clk) begin
    if (we) mem_q[addr[MEM_AW-1:0]] <= wdata;
  end
endmodule

// File: rtl/alias_wb_cache.sv
module alias_wb_cache
  import awc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int NUM_LINES  = 64,
  parameter int MEM_WORDS  = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_err
);
  localparam int BYTE_W     = $clog2(DATA_W / 8);
  localparam int LINE_WORDS = LINE_BYTES / (DATA_W / 8);
  localparam int WORD_W     = $clog2(LINE_WORDS);
  localparam int IDX_W      = $clog2(NUM_LINES);
  localparam int PHYS_W     = ADDR_W - 3;
  localparam int PWORD_W    = PHYS_W - BYTE_W;
  localparam int TAG_W      = PWORD_W - IDX_W - WORD_W;
  localparam logic [WORD_W-1:0] LAST_BEAT = WORD_W'(LINE_WORDS - 1);

  logic              rst_sync_n;
  win_t              win;
  logic [PHYS_W-1:0] phys;
  logic [WORD_W-1:0] req_word;
  logic [IDX_W-1:0]  req_idx;
  logic [TAG_W-1:0]  req_tag;
  logic              unused_byte;

  ctl_state_t        state_q, state_d;
  logic [WORD_W-1:0] beat_q, beat_d;

  logic [WORD_W-1:0] ls_word;
  logic [DATA_W-1:0] ls_rdata, ls_wdata;
  logic [TAG_W-1:0]  ls_tag;
  logic              ls_valid, ls_dirty, ls_wr, ls_set_dirty, ls_fill;
  logic              hit;
  logic [NUM_LINES-1:0] valid_vec, dirty_vec;

  logic               mem_we;
  logic [PWORD_W-1:0] mem_addr;
  logic [DATA_W-1:0]  mem_wdata, mem_rdata;

  awc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  awc_decode #(.ADDR_W(ADDR_W)) u_dec (.addr(cpu_addr), .win(win), .phys(phys));

  assign req_word    = phys[BYTE_W +: WORD_W];
  assign req_idx     = phys[BYTE_W + WORD_W +: IDX_W];
  assign req_tag     = phys[PHYS_W-1 -: TAG_W];
  assign unused_byte = ^phys[BYTE_W-1:0];

  awc_line_store #(
    .NUM_LINES(NUM_LINES), .LINE_WORDS(LINE_WORDS), .TAG_W(TAG_W), .DATA_W(DATA_W)
  ) u_lines (
    .clk(clk), .rst_n(rst_sync_n), .idx(req_idx), .word(ls_word),
    .rd_data(ls_rdata), .rd_tag(ls_tag), .rd_valid(ls_valid), .rd_dirty(ls_dirty),
    .wr_en(ls_wr), .wr_data(ls_wdata), .set_dirty(ls_set_dirty),
    .fill_done(ls_fill), .fill_tag(req_tag),
    .valid_vec(valid_vec), .dirty_vec(dirty_vec)
  );

  awc_phys_mem #(.AW(PWORD_W), .DEPTH(MEM_WORDS), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .we(mem_we), .addr(mem_addr), .wdata(mem_wdata), .rdata(mem_rdata)
  );

  assign hit = ls_valid && (ls_tag == req_tag);

  always_comb begin
    state_d      = state_q;
    beat_d       = beat_q;
    cpu_ready    = 1'b0;
    cpu_err      = 1'b0;
    cpu_rdata    = '0;
    ls_word      = req_word;
    ls_wr        = 1'b0;
    ls_wdata     = cpu_wdata;
    ls_set_dirty = 1'b0;
    ls_fill      = 1'b0;
    mem_we       = 1'b0;
    mem_addr     = phys[PHYS_W-1:BYTE_W];
    mem_wdata    = cpu_wdata;
    case (state_q)
      ST_IDLE: begin
        if (cpu_valid) begin
          if (win == WIN_CACHED) begin
            if (hit) begin
              cpu_ready    = 1'b1;
              cpu_rdata    = ls_rdata;
              ls_wr        = cpu_we;
              ls_set_dirty = cpu_we;
            end else begin
              beat_d  = '0;
              state_d = (ls_valid && ls_dirty) ? ST_WBACK : ST_FILL;
            end
          end else begin
            mem_we    = cpu_we;
            cpu_ready = 1'b1;
            cpu_rdata = mem_rdata;
            cpu_err   = (win == WIN_OTHER);
          end
        end
      end
      ST_WBACK: begin
        ls_word   = beat_q;
        mem_we    = 1'b1;
        mem_addr  = {ls_tag, req_idx, beat_q};
        mem_wdata = ls_rdata;
        beat_d    = beat_q + 1'b1;
        if (beat_q == LAST_BEAT) begin
          beat_d  = '0;
          state_d = ST_FILL;
        end
      end
      ST_FILL: begin
        ls_word  = beat_q;
        ls_wr    = 1'b1;
        ls_wdata = mem_rdata;
        mem_addr = {req_tag, req_idx, beat_q};
        beat_d   = beat_q + 1'b1;
        if (beat_q == LAST_BEAT) begin
          beat_d  = '0;
          ls_fill = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
    end
  end
endmodule

// File: rtl/awc_checker.sv
module awc_checker
  import awc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int NUM_LINES = 64,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_valid,
  input logic              cpu_we,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [DATA_W-1:0] cpu_wdata,
  input logic              cpu_ready,
  input logic              cpu_err,
  input ctl_state_t        state,
  input win_t              win,
  input logic              hit,
  input logic              fill_done,
  input logic [IDX_W-1:0]  idx,
  input logic [NUM_LINES-1:0] valid_vec,
  input logic [NUM_LINES-1:0] dirty_vec
);
  logic cached_req;
  assign cached_req = (state == ST_IDLE) && cpu_valid && (win == WIN_CACHED);

  assert_ready_needs_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_valid);

  assert_req_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && !cpu_ready) |=> (cpu_valid && $stable(cpu_addr) && $stable(cpu_we)
                                   && $stable(cpu_wdata)));

  assert_hit_no_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cached_req && hit) |-> cpu_ready);

  assert_uncached_keeps_lines_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_IDLE) && cpu_valid && (win != WIN_CACHED)) |=>
      ($stable(valid_vec) && $stable(dirty_vec)));

  assert_burst_stalls_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |-> !cpu_ready);

  assert_fill_leaves_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> (valid_vec[$past(idx)] && !dirty_vec[$past(idx)]));

  assert_dirty_victim_written_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cached_req && !hit && valid_vec[idx] && dirty_vec[idx]) |=> (state == ST_WBACK));

  assert_err_outside_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> (cpu_err == (win == WIN_OTHER)));
endmodule

bind alias_wb_cache awc_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_LINES(NUM_LINES)
) u_awc_checker (
  .clk(clk), .rst_n(rst_sync_n), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
  .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_err(cpu_err),
  .state(state_q), .win(win), .hit(hit), .fill_done(ls_fill), .idx(req_idx),
  .valid_vec(valid_vec), .dirty_vec(dirty_vec)
);

// File: tb/tb_alias_wb_cache.sv
`timescale 1ns/1ps
module tb_alias_wb_cache;
  logic        clk;
  logic        rst_n;
  logic        cpu_valid;
  logic        cpu_we;
  logic [31:0] cpu_addr;
  logic [31:0] cpu_wdata;
  logic        cpu_ready;
  logic [31:0] cpu_rdata;
  logic        cpu_err;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  alias_wb_cache dut (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
    .cpu_rdata(cpu_rdata), .cpu_err(cpu_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic access(input bit we, input logic [31:0] addr, input logic [31:0] wd,
                        output logic [31:0] rd, output bit er, output int lat);
    @(negedge clk);
    cpu_valid = 1'b1;
    cpu_we    = we;
    cpu_addr  = addr;
    cpu_wdata = wd;
    lat = 0;
    #1;
    while (!cpu_ready && lat < 100) begin
      @(negedge clk);
      #1;
      lat++;
    end
    rd = cpu_rdata;
    er = cpu_err;
    @(posedge clk);
    #1;
    cpu_valid = 1'b0;
    cpu_we    = 1'b0;
  endtask

  task automatic wr(input logic [31:0] addr, input logic [31:0] wd);
    logic [31:0] rd; bit er; int lat;
    access(1'b1, addr, wd, rd, er, lat);
  endtask

  task automatic t_reset();
    #1;
    check("R10", "ready after reset", {31'd0, cpu_ready}, 32'd0);
    check("R10", "err after reset", {31'd0, cpu_err}, 32'd0);
  endtask

  task automatic t_alias_fill();
    logic [31:0] rd; bit er; int lat;
    wr(32'hA000_0100, 32'h0000_1111);
    wr(32'hA000_0104, 32'hAAAA_0104);
    access(1'b0, 32'hA000_0100, 0, rd, er, lat);
    check("R2", "uncached readback", rd, 32'h0000_1111);
    access(1'b0, 32'h8000_0100, 0, rd, er, lat);
    check("R2", "cached alias data", rd, 32'h0000_1111);
    check("R10", "first cached access misses", lat, 9);
    check("R6", "clean miss latency", lat, 9);
    access(1'b0, 32'h8000_0104, 0, rd, er, lat);
    check("R3", "hit latency", lat, 0);
    check("R3", "hit data other word", rd, 32'hAAAA_0104);
  endtask

  task automatic t_deferred_write();
    logic [31:0] rd; bit er; int lat;
    access(1'b1, 32'h8000_0100, 32'h0000_2222, rd, er, lat);
    check("R3", "write hit latency", lat, 0);
    access(1'b0, 32'hA000_0100, 0, rd, er, lat);
    check("R4", "memory unchanged by cached write", rd, 32'h0000_1111);
  endtask

  task automatic t_uncached_bypass();
    logic [31:0] rd; bit er; int lat;
    wr(32'hA000_0100, 32'h0000_3333);
    wr(32'hA000_0104, 32'h0000_5555);
    access(1'b0, 32'h8000_0100, 0, rd, er, lat);
    check("R5", "cached hit keeps stale data", rd, 32'h0000_2222);
    check("R5", "still a hit after uncached write", lat, 0);
    access(1'b0, 32'hA000_0100, 0, rd, er, lat);
    check("R5", "uncached sees memory", rd, 32'h0000_3333);
  endtask

  task automatic t_dirty_evict();
    logic [31:0] rd; bit er; int lat;
    wr(32'hA000_0900, 32'h0000_4444);
    access(1'b0, 32'h8000_0900, 0, rd, er, lat);
    check("R6", "dirty miss latency", lat, 17);
    check("R6", "conflict line data", rd, 32'h0000_4444);
    access(1'b0, 32'hA000_0100, 0, rd, er, lat);
    check("R7", "eviction overwrote newer word", rd, 32'h0000_2222);
    access(1'b0, 32'hA000_0104, 0, rd, er, lat);
    check("R7", "whole line written back", rd, 32'hAAAA_0104);
  endtask

  task automatic t_outside();
    logic [31:0] rd; bit er; int lat;
    access(1'b1, 32'h0000_0200, 32'h0000_6666, rd, er, lat);
    check("R9", "err on low window", {31'd0, er}, 32'd1);
    access(1'b0, 32'hA000_0200, 0, rd, er, lat);
    check("R9", "outside write reached memory", rd, 32'h0000_6666);
    check("R9", "no err in uncached window", {31'd0, er}, 32'd0);
    access(1'b0, 32'hC000_0200, 0, rd, er, lat);
    check("R9", "outside read data", rd, 32'h0000_6666);
    check("R9", "err on high window", {31'd0, er}, 32'd1);
  endtask

  task automatic t_write_alloc();
    logic [31:0] rd; bit er; int lat;
    wr(32'hA000_0400, 32'h0000_0400);
    wr(32'hA000_0404, 32'h0000_7777);
    access(1'b1, 32'h8000_0400, 32'h0000_8888, rd, er, lat);
    check("R11", "write miss latency", lat, 9);
    check("R9", "no err in cached window", {31'd0, er}, 32'd0);
    access(1'b0, 32'h8000_0404, 0, rd, er, lat);
    check("R11", "neighbour word from memory", rd, 32'h0000_7777);
    access(1'b0, 32'h8000_0400, 0, rd, er, lat);
    check("R11", "written word", rd, 32'h0000_8888);
    access(1'b0, 32'hA000_0400, 0, rd, er, lat);
    check("R4", "allocated write not in memory", rd, 32'h0000_0400);
  endtask

  task automatic t_flush_walk();
    logic [31:0] rd; bit er; int lat;
    wr(32'h8000_0040, 32'hF1F1_0040);
    wr(32'h8000_07E0, 32'hF1F1_07E0);
    for (int i = 0; i < 64; i++) begin
      access(1'b0, 32'h8000_0800 + 32'(i * 32), 0, rd, er, lat);
    end
    access(1'b0, 32'hA000_0040, 0, rd, er, lat);
    check("R8", "flushed line 2", rd, 32'hF1F1_0040);
    access(1'b0, 32'hA000_07E0, 0, rd, er, lat);
    check("R8", "flushed line 63", rd, 32'hF1F1_07E0);
    access(1'b0, 32'hA000_0400, 0, rd, er, lat);
    check("R8", "flushed line 32", rd, 32'h0000_8888);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    cpu_valid = 1'b0;
    cpu_we    = 1'b0;
    cpu_addr  = '0;
    cpu_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_alias_fill();
    t_deferred_write();
    t_uncached_bypass();
    t_dirty_evict();
    t_outside();
    t_write_alloc();
    t_flush_walk();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule